// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps time of day and the calendar in packed BCD. It holds hundredths of a second, seconds, minutes, 24-hour hours, day of week, day of month, month, a two-digit year and a century flag. It advances them from a slow enable input that pulses at the time-base rate, normally 32.768 kHz. An internal fractional prescaler turns those pulses into an exact long-run 100 Hz tick. Each tick adds one hundredth of a second, and carries ripple through every field in the same clock cycle.

A host sets the fields one byte at a time through a write port using a valid/ready handshake. The port never applies back-pressure: `wr_ready` is always high, so a byte is taken in every cycle in which `wr_valid` is high. Any accepted write zeroes the hundredths and restarts the prescaler, so the first tick after the write comes a full tick period later. A stop bit held in the seconds byte freezes the prescaler and all counters. The current value of every field is always present on the byte-wide outputs.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the outputs read hundredths 00, seconds 00 with the stop bit clear, minutes 00, hours 00 with both century bits clear, day of week 1, date 01, month 01 and year 00.
- R2: Each tick raises the hundredths by one in BCD. At 99 the hundredths wrap to 00 and carry into the seconds.
- R3: The prescaler adds TICK_HZ for each cycle with `src_en` high and raises a tick once the running total reaches SRC_HZ, keeping the remainder. With SRC_HZ=5 and TICK_HZ=2, counting from a cleared prescaler, ticks fall on the 3rd and 5th enabled cycles, and that pattern repeats.
- R4: Seconds and minutes count 00 to 59 and hours 00 to 23, each in BCD. Each field wraps to 00 and carries to the next field on the same tick. In `hour_o`, bit 7 is the century enable, bit 6 is the century flag and bits 5:0 are the hours.
- R5: The day of week sits in bits 2:0 of `dow_o` (bits 7:3 read 0). It advances once per day rollover and wraps from 7 to 1.
- R6: The date wraps to 01 after the last day of the month. April, June, September and November have 30 days, and every other month except February has 31. February has 29 days when the year value is divisible by 4, otherwise 28.
- R7: After the last day of month 12, the month wraps to 01 and the year advances. The year wraps from 99 to 00, and on that wrap the century flag toggles if the century enable is 1 and holds if it is 0.
- R8: While bit 7 of `sec_o` (the stop bit) is 1, no field changes, however many `src_en` pulses arrive, until a write clears the stop bit.
- R9: With `wr_valid` high, `wr_data` is stored at the next edge into the field chosen by `wr_sel`: 0 hundredths, 1 seconds (bit 7 is stop), 2 minutes, 3 hours with century bits, 4 day of week, 5 date, 6 month, 7 year. The hundredths field only ever takes 00. Any write sets the hundredths to 00 and clears the prescaler total.
- R10: When a write and a tick-producing `src_en` fall in the same cycle, the write wins. The written value appears, the hundredths read 00, and the tick is dropped along with the prescaler total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 1 | Time-base enable, one pulse per time-base period |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write acceptance, always high |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | BCD byte to write |
| hund_o | output | 8 | Hundredths of a second |
| sec_o | output | 8 | Stop bit and seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Century enable, century flag, hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
A host write and a prescaler tick can fall in the same clock edge. The bench provokes this by enabling the time base until the prescaler sits one pulse short of a tick, then raising `wr_valid` together with `src_en`. The outcome is judged at the ports. The written byte must appear with hundredths 00, and the next tick must need a full, fresh count of enables. A leftover prescaler total would make that tick arrive early. Carries from hundredths up to the century flag also collapse into one edge, and these are driven from randomized near-boundary dates against a calendar model in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    SEL_HUND  = 3'd0,
    SEL_SEC   = 3'd1,
    SEL_MIN   = 3'd2,
    SEL_HOUR  = 3'd3,
    SEL_DOW   = 3'd4,
    SEL_DATE  = 3'd5,
    SEL_MONTH = 3'd6,
    SEL_YEAR  = 3'd7
  } rtc_sel_e;

  // Two-digit BCD increment without wrap handling.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a BCD month; leap when the BCD year is a multiple of four.
  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [5:0] rem_sum;
    rem_sum = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    case (mon)
      8'h02:                      return ((rem_sum % 6'd4) == 6'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned SRC_HZ  = 32768,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic src_en,
  output logic tick
);
  localparam int unsigned AW = $clog2(SRC_HZ + TICK_HZ + 1);
  localparam logic [AW-1:0] STEP = AW'(TICK_HZ);
  localparam logic [AW-1:0] LIM  = AW'(SRC_HZ);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] sum;

  assign sum  = acc_q + STEP;
  assign tick = run && src_en && !clr && (sum >= LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (run && src_en) acc_q <= tick ? (sum - LIM) : sum;
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) acc_q < LIM); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> acc_q == '0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(run && src_en)) |=> $stable(acc_q)); // R8

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_fire,
  input  rtc_sel_e   wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] hund_q,
  output logic       stop_q,
  output logic [6:0] sec_q,
  output logic [6:0] min_q,
  output logic [5:0] hour_q,
  output logic       day_inc
);
  logic c_h, c_s, c_m, c_d;

  assign c_h = (hund_q == 8'h99);
  assign c_s = c_h && (sec_q == 7'h59);
  assign c_m = c_s && (min_q == 7'h59);
  assign c_d = c_m && (hour_q == 6'h23);
  assign day_inc = tick && c_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hund_q <= 8'h00;
      stop_q <= 1'b0;
      sec_q  <= 7'h00;
      min_q  <= 7'h00;
      hour_q <= 6'h00;
    end else if (wr_fire) begin
      hund_q <= 8'h00;
      case (wr_sel)
        SEL_SEC: begin
          stop_q <= wr_data[7];
          sec_q  <= wr_data[6:0];
        end
        SEL_MIN:  min_q  <= wr_data[6:0];
        SEL_HOUR: hour_q <= wr_data[5:0];
        default: ;
      endcase
    end else if (tick) begin
      hund_q <= c_h ? 8'h00 : bcd_inc(hund_q);
      if (c_h) sec_q  <= c_s ? 7'h00 : 7'(bcd_inc({1'b0, sec_q}));
      if (c_s) min_q  <= c_m ? 7'h00 : 7'(bcd_inc({1'b0, min_q}));
      if (c_m) hour_q <= c_d ? 6'h00 : 6'(bcd_inc({2'b00, hour_q}));
    end
  end

  AST_HUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hund_q[3:0] != 4'h9) |=> hund_q == $past(hund_q) + 8'd1); // R2
  AST_HUND_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    hund_q[3:0] <= 4'h9 && hund_q[7:4] <= 4'h9); // R2
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && sec_q <= 7'h59) |=> sec_q <= 7'h59); // R4
  AST_WRITE_ZERO_HUND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> hund_q == 8'h00); // R9

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_inc,
  input  logic       wr_fire,
  input  rtc_sel_e   wr_sel,
  input  logic [7:0] wr_data,
  output logic [2:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q,
  output logic       cen_en_q,
  output logic       cent_q
);
  logic last_day, c_mo, c_y, c_c;

  assign last_day = (date_q == month_len(month_q, year_q));
  assign c_mo = day_inc && last_day;
  assign c_y  = c_mo && (month_q == 8'h12);
  assign c_c  = c_y && (year_q == 8'h99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow_q    <= 3'd1;
      date_q   <= 8'h01;
      month_q  <= 8'h01;
      year_q   <= 8'h00;
      cen_en_q <= 1'b0;
      cent_q   <= 1'b0;
    end else if (wr_fire) begin
      case (wr_sel)
        SEL_HOUR: begin
          cen_en_q <= wr_data[7];
          cent_q   <= wr_data[6];
        end
        SEL_DOW:   dow_q   <= wr_data[2:0];
        SEL_DATE:  date_q  <= wr_data;
        SEL_MONTH: month_q <= wr_data;
        SEL_YEAR:  year_q  <= wr_data;
        default: ;
      endcase
    end else if (day_inc) begin
      dow_q  <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      date_q <= last_day ? 8'h01 : bcd_inc(date_q);
      if (c_mo) month_q <= c_y ? 8'h01 : bcd_inc(month_q);
      if (c_y)  year_q  <= c_c ? 8'h00 : bcd_inc(year_q);
      if (c_c && cen_en_q) cent_q <= ~cent_q;
    end
  end

  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !wr_fire && dow_q >= 3'd1) |=> dow_q >= 3'd1); // R5
  AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !wr_fire) |=> date_q != 8'h00); // R6
  AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !cen_en_q) |=> $stable(cent_q)); // R7

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int unsigned SRC_HZ  = 32768,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_en,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] hund_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic       wr_fire, tick, day_inc;
  logic       stop_q, cen_en_q, cent_q;
  logic [7:0] hund_q, date_q, month_q, year_q;
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q;
  logic [2:0] dow_q;
  rtc_sel_e   sel;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid;
  assign sel      = rtc_sel_e'(wr_sel);

  rtc_prescaler #(.SRC_HZ(SRC_HZ), .TICK_HZ(TICK_HZ)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(wr_fire), .run(!stop_q),
    .src_en(src_en), .tick(tick)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_fire(wr_fire),
    .wr_sel(sel), .wr_data(wr_data), .hund_q(hund_q), .stop_q(stop_q),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_inc(day_inc)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_inc(day_inc), .wr_fire(wr_fire),
    .wr_sel(sel), .wr_data(wr_data), .dow_q(dow_q), .date_q(date_q),
    .month_q(month_q), .year_q(year_q), .cen_en_q(cen_en_q), .cent_q(cent_q)
  );

  assign hund_o  = hund_q;
  assign sec_o   = {stop_q, sec_q};
  assign min_o   = {1'b0, min_q};
  assign hour_o  = {cen_en_q, cent_q, hour_q};
  assign dow_o   = {5'b00000, dow_q};
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_valid) |=> $stable({hund_q, sec_q, min_q, hour_q, dow_q,
                                       date_q, month_q, year_q, cent_q})); // R8
  AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !tick); // R10

endmodule

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
  localparam int B_SRC  = 5;
  localparam int B_TICK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_en = 1'b0;
  logic wr_valid = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready;
  logic [7:0] hund_o, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_h, m_s, m_mi, m_hr, m_dw, m_dt, m_mo, m_yr, m_acc, m_ticks;
  bit m_cen, m_cb, m_stop;

  always #5 clk = ~clk;

  rtc_calendar_core #(.SRC_HZ(B_SRC), .TICK_HZ(B_TICK)) uut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_ticks++;
    m_h++;
    if (m_h == 100) begin
      m_h = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            m_dw = (m_dw == 7) ? 1 : m_dw + 1;
            m_dt++;
            if (m_dt > days_in(m_mo, m_yr)) begin
              m_dt = 1; m_mo++;
              if (m_mo > 12) begin
                m_mo = 1; m_yr++;
                if (m_yr == 100) begin
                  m_yr = 0;
                  if (m_cen) m_cb = ~m_cb;
                end
              end
            end
          end
        end
      end
    end
  endtask

  task automatic model_enable();
    if (!m_stop) begin
      m_acc += B_TICK;
      if (m_acc >= B_SRC) begin
        m_acc -= B_SRC;
        model_tick();
      end
    end
  endtask

  task automatic model_write(input logic [2:0] sel, input logic [7:0] d);
    m_h = 0; m_acc = 0;
    case (sel)
      3'd1: begin m_stop = d[7]; m_s = from_bcd({1'b0, d[6:0]}); end
      3'd2: m_mi = from_bcd({1'b0, d[6:0]});
      3'd3: begin m_cen = d[7]; m_cb = d[6]; m_hr = from_bcd({2'b00, d[5:0]}); end
      3'd4: m_dw = int'(d[2:0]);
      3'd5: m_dt = from_bcd(d);
      3'd6: m_mo = from_bcd(d);
      3'd7: m_yr = from_bcd(d);
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input string nm, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "hund", hund_o, to_bcd(m_h));
    chk(req, "sec", sec_o, {m_stop, 7'(to_bcd(m_s))});
    chk(req, "min", min_o, to_bcd(m_mi));
    chk(req, "hour", hour_o, {m_cen, m_cb, 6'(to_bcd(m_hr))});
    chk(req, "dow", dow_o, 8'(m_dw));
    chk(req, "date", date_o, to_bcd(m_dt));
    chk(req, "month", month_o, to_bcd(m_mo));
    chk(req, "year", year_o, to_bcd(m_yr));
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(sel, d);
  endtask

  task automatic collide(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; src_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; src_en = 1'b0;
    model_write(sel, d);
  endtask

  task automatic enables(input int n);
    src_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_enable();
    end
    src_en = 1'b0;
  endtask

  task automatic run_ticks(input int k);
    int start;
    start = m_ticks;
    src_en = 1'b1;
    while (m_ticks - start < k) begin
      @(negedge clk);
      model_enable();
    end
    src_en = 1'b0;
  endtask

  task automatic set_all(input int s, input int mi, input int hr, input bit cen, input bit cb,
                         input int dw, input int dt, input int mo, input int yr);
    do_write(3'd7, to_bcd(yr));
    do_write(3'd6, to_bcd(mo));
    do_write(3'd5, to_bcd(dt));
    do_write(3'd4, 8'(dw));
    do_write(3'd3, {cen, cb, 6'(to_bcd(hr))});
    do_write(3'd2, to_bcd(mi));
    do_write(3'd1, {1'b0, 7'(to_bcd(s))});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd7321);
    m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; m_dw = 1; m_dt = 1; m_mo = 1; m_yr = 0;
    m_acc = 0; m_ticks = 0; m_cen = 0; m_cb = 0; m_stop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    chk("R9", "wr_ready", {7'b0, wr_ready}, 8'h01);

    // R3: fractional prescaler, ticks on enables 3 and 5
    set_all(10, 20, 5, 0, 0, 2, 14, 6, 41);
    enables(2);
    chk("R3", "hund_after2", hund_o, 8'h00);
    enables(1);
    chk("R3", "hund_after3", hund_o, 8'h01);
    enables(1);
    chk("R3", "hund_after4", hund_o, 8'h01);
    enables(1);
    chk("R3", "hund_after5", hund_o, 8'h02);
    check_all("R3");

    // R2 and R4: full carry from hundredths to the day
    set_all(59, 59, 23, 0, 0, 3, 10, 5, 30);
    run_ticks(99);
    chk("R2", "hund99", hund_o, 8'h99);
    check_all("R2");
    run_ticks(1);
    chk("R4", "hour_wrap", hour_o, 8'h00);
    check_all("R4");

    // R6: leap and non-leap February, 30- and 31-day months
    set_all(59, 59, 23, 0, 0, 7, 28, 2, 24);
    run_ticks(100);
    chk("R6", "leap_feb29", date_o, 8'h29);
    chk("R5", "dow_wrap", dow_o, 8'h01);
    do_write(3'd3, 8'h23); do_write(3'd2, 8'h59); do_write(3'd1, 8'h59);
    run_ticks(100);
    chk("R6", "leap_mar1", month_o, 8'h03);
    check_all("R6");
    set_all(59, 59, 23, 0, 0, 4, 28, 2, 23);
    run_ticks(100);
    chk("R6", "plain_mar1", date_o, 8'h01);
    check_all("R6");
    set_all(59, 59, 23, 0, 0, 4, 30, 4, 50);
    run_ticks(100);
    check_all("R6");
    set_all(59, 59, 23, 0, 0, 1, 31, 1, 50);
    run_ticks(100);
    check_all("R6");

    // R7: year and century rollover
    set_all(59, 59, 23, 1, 0, 5, 31, 12, 99);
    run_ticks(100);
    chk("R7", "cent_toggle", hour_o, 8'hC0);
    check_all("R7");
    set_all(59, 59, 23, 0, 1, 5, 31, 12, 99);
    run_ticks(100);
    chk("R7", "cent_hold", hour_o, 8'h40);
    check_all("R7");

    // R8: stop freezes everything
    set_all(12, 34, 10, 0, 0, 2, 3, 4, 5);
    run_ticks(7);
    do_write(3'd1, 8'h92);
    enables(40);
    chk("R8", "stopped_hund", hund_o, 8'h00);
    check_all("R8");
    do_write(3'd1, 8'h12);
    run_ticks(3);
    check_all("R8");

    // R9: hundredths write stores 00, any write zeroes hundredths
    run_ticks(37);
    do_write(3'd0, 8'h47);
    chk("R9", "hund_write", hund_o, 8'h00);
    run_ticks(15);
    do_write(3'd2, 8'h41);
    check_all("R9");

    // R10: write and tick in the same cycle
    set_all(0, 0, 8, 0, 0, 1, 1, 1, 1);
    run_ticks(4);
    enables(2);
    collide(3'd2, 8'h33);
    chk("R10", "collide_hund", hund_o, 8'h00);
    chk("R10", "collide_min", min_o, 8'h33);
    enables(2);
    chk("R10", "fresh_count", hund_o, 8'h00);
    enables(1);
    chk("R10", "first_tick", hund_o, 8'h01);
    check_all("R10");

    // Random near-boundary dates (R4 R5 R6 R7)
    for (int it = 0; it < 20; it++) begin
      int mo, yr, dt;
      mo = int'($urandom_range(1, 12));
      yr = ($urandom_range(0, 3) == 0) ? 99 : int'($urandom_range(0, 98));
      dt = days_in(mo, yr) - int'($urandom_range(0, 1));
      set_all(int'($urandom_range(58, 59)), 59, int'($urandom_range(22, 23)),
              bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
              int'($urandom_range(1, 7)), dt, mo, yr);
      run_ticks(int'($urandom_range(100, 300)));
      check_all("R4 R5 R6 R7 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule